// File: doc/BRIEF.md
# BCH Correction Applier for One 512-Byte Sector

This block takes the bit-error locations that a BCH error locator reports for one 512-byte sector and turns each one into an actual bit flip. The sector and its check bytes are treated as a single codeword: the data bytes come first and the ECC bytes follow. Locator positions count backwards from the last codeword byte. Each location becomes a byte index and a bit index. A flip that falls in the data part is applied to the external sector buffer by a read followed by a write. A flip that falls in the check part is applied to an internal copy of the stored ECC bytes, which is presented on an output port. A location that points past the start of the codeword is counted as an error.

A session begins with a `start` pulse. That pulse captures the strength mode, the computed ECC bytes, the ECC bytes read from the spare area, and the number of locations to expect. Two shortcuts are tested first, and either one ends the session at once with no buffer access: a computed ECC that is entirely zero means the sector is clean, and stored ECC bytes that are all 0xFF mean the page is erased. The block also puts out the computed ECC bytes in reversed order, which is the form the locator needs.

When a session ends, the block raises `done` for one cycle. It then holds the number of corrected bits, or a failure flag if any location was invalid.

Top module: `bch_fix_applier`

## Requirements
- R1: While reset is held and after reset is released, `done`, `loc_ready`, `buf_rd_en`, `buf_wr_en`, `fail` and `corrected` are all 0.
- R2: If computed ECC bytes 0..12 (in 8-bit mode, `mode`=0) or 0..25 (in 16-bit mode, `mode`=1) are all 0x00, the session ends with `done` two cycles after `start`, with `fail`=0 and `corrected`=0. No location is taken, nothing in the buffer changes, and `ecc_fixed` equals the stored bytes. Computed byte 13 in 8-bit mode is padding and is not checked.
- R3: If stored ECC bytes 0..12 (8-bit mode) or 0..25 (16-bit mode) are all 0xFF, the session ends in the same way as in R2.
- R4: In 8-bit mode the codeword is 525 bytes long. A location L maps to byte 524-(L/8) and bit L mod 8. The largest valid location is 4199.
- R5: In 16-bit mode the codeword is 538 bytes long. A location L maps to byte 537-(L/8) and bit L mod 8. The largest valid location is 4303.
- R6: A byte position below 512 reads buffer byte `buf_addr` in one cycle and writes the same address in the next cycle with that one bit inverted. The buffer returns read data one cycle after `buf_rd_en`. Byte i of a flat ECC vector sits at bits [8i+7:8i].
- R7: A byte position from 512 up to the codeword length minus 1 inverts the bit in byte (position-512) of `ecc_fixed`. `ecc_fixed` is loaded from `stored_ecc` at `start`.
- R8: A location with L/8 at or beyond the codeword length changes nothing. It sets `fail`=1 and forces `corrected` to 0 for that session. Later locations in the same session are still applied.
- R9: A session without invalid locations ends with `corrected` equal to the number of applied flips.
- R10: `syn_out` byte i equals computed byte 12-i for i<13 in 8-bit mode, with bytes 13..25 passed through unchanged. In 16-bit mode byte i equals computed byte 25-i.
- R11: A location is taken only when `loc_valid` and `loc_ready` are both high. `loc_ready` stays low while a buffer read-modify-write is in progress.
- R12: A session with a location count of 0 ends with `corrected`=0 and `fail`=0, and no location is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a session; taken only while idle |
| mode | input | 1 | 0 = 8-bit strength, 1 = 16-bit strength |
| loc_count | input | 5 | Number of locations in this session |
| calc_ecc | input | 208 | ECC bytes computed over the read data |
| stored_ecc | input | 208 | ECC bytes read from the spare area |
| syn_out | output | 208 | Computed ECC in the order the locator needs |
| loc_valid | input | 1 | Location available |
| loc_data | input | 13 | Bit-error location |
| loc_ready | output | 1 | Block accepts a location |
| buf_rd_en | output | 1 | Sector buffer read strobe |
| buf_wr_en | output | 1 | Sector buffer write strobe |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_wr_data | output | 8 | Corrected byte to write |
| buf_rd_data | input | 8 | Buffer read data, one cycle after the strobe |
| ecc_fixed | output | 208 | Stored ECC bytes with corrections applied |
| done | output | 1 | One-cycle end-of-session pulse |
| fail | output | 1 | Session contained an invalid location |
| corrected | output | 5 | Number of bits corrected (0 on failure) |

## Verification
The bench uses the default parameters: a 512-byte sector, a 26-byte maximum ECC field and a 5-bit location count. With these values every edge of both codewords can be reached with real locations. That includes the last data byte (511), the first and last check bytes, byte 0 at the top of the location range, and the first location that is out of range in each mode. The shortcut tests put a non-matching value in padding byte 13 and in the bytes beyond it. This shows that the zero and erased tests look only at the bytes that belong to the selected strength.

// File: rtl/bfa_pkg.sv
package bfa_pkg;
  localparam int SECTOR_B = 512;
  localparam int ECC_B8   = 13;
  localparam int ECC_B16  = 26;
  localparam int ECC_MAXB = 26;
  localparam int POS_W    = $clog2(SECTOR_B + ECC_MAXB);
  localparam int LOC_W    = POS_W + 3;
  localparam int BIDX_W   = $clog2(SECTOR_B);
  localparam int EIDX_W   = $clog2(ECC_MAXB);

  typedef enum logic {STR_T8 = 1'b0, STR_T16 = 1'b1} strength_e;
  typedef enum logic [1:0] {HIT_DATA, HIT_ECC, HIT_BAD} hit_e;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHECK, ST_TAKE, ST_READ, ST_WRITE, ST_DONE
  } phase_e;

  // Number of meaningful check bytes for a strength.
  function automatic logic [POS_W-1:0] ecc_len(strength_e s);
    return (s == STR_T16) ? POS_W'(ECC_B16) : POS_W'(ECC_B8);
  endfunction

  // Codeword length in bytes: sector followed by its check bytes.
  function automatic logic [POS_W-1:0] cw_len(strength_e s);
    return POS_W'(SECTOR_B) + ecc_len(s);
  endfunction

  // Byte position of a reversed-order locator bit index.
  function automatic logic [POS_W-1:0] byte_pos(strength_e s,
                                                 logic [POS_W-1:0] lbyte);
    return cw_len(s) - lbyte - POS_W'(1);
  endfunction
endpackage

// File: rtl/bfa_loc_map.sv
module bfa_loc_map
  import bfa_pkg::*;
#(
  parameter int SEC = SECTOR_B,
  parameter int LW  = LOC_W,
  parameter int PW  = POS_W,
  parameter int AW  = BIDX_W,
  parameter int IW  = EIDX_W
) (
  input  strength_e        str,
  input  logic [LW-1:0]    loc,
  output hit_e             hit,
  output logic [AW-1:0]    daddr,
  output logic [IW-1:0]    eidx,
  output logic [2:0]       bsel
);
  logic [PW-1:0] lbyte;
  logic [PW-1:0] pos;

  always_comb begin
    lbyte = loc[LW-1:3];
    bsel  = loc[2:0];
    pos   = byte_pos(str, lbyte);
    daddr = AW'(pos);
    eidx  = IW'(pos - PW'(SEC));
    if (lbyte >= cw_len(str))
      hit = HIT_BAD;
    else if (pos < PW'(SEC))
      hit = HIT_DATA;
    else
      hit = HIT_ECC;
  end
endmodule

// File: rtl/bfa_skip_detect.sv
module bfa_skip_detect
  import bfa_pkg::*;
#(
  parameter int NB = ECC_MAXB
) (
  input  strength_e         str,
  input  logic [NB*8-1:0]   calc,
  input  logic [NB*8-1:0]   stored,
  output logic              calc_clean,
  output logic              stored_blank
);
  logic [NB-1:0] zero_ok;
  logic [NB-1:0] blank_ok;

  for (genvar i = 0; i < NB; i++) begin : g_byte
    logic used;
    assign used        = POS_W'(i) < ecc_len(str);
    assign zero_ok[i]  = !used || (calc[8*i +: 8] == 8'h00);
    assign blank_ok[i] = !used || (stored[8*i +: 8] == 8'hFF);
  end

  assign calc_clean   = &zero_ok;
  assign stored_blank = &blank_ok;
endmodule

// File: rtl/bfa_syn_order.sv
module bfa_syn_order
  import bfa_pkg::*;
#(
  parameter int NB  = ECC_MAXB,
  parameter int NB8 = ECC_B8
) (
  input  strength_e        str,
  input  logic [NB*8-1:0]  calc,
  output logic [NB*8-1:0]  syn
);
  for (genvar i = 0; i < NB; i++) begin : g_rev
    if (i < NB8) begin : g_low
      assign syn[8*i +: 8] = (str == STR_T16) ? calc[8*(NB-1-i) +: 8]
                                              : calc[8*(NB8-1-i) +: 8];
    end else begin : g_high
      assign syn[8*i +: 8] = (str == STR_T16) ? calc[8*(NB-1-i) +: 8]
                                              : calc[8*i +: 8];
    end
  end
endmodule

// File: rtl/bfa_ecc_copy.sv
module bfa_ecc_copy
  import bfa_pkg::*;
#(
  parameter int NB = ECC_MAXB,
  parameter int IW = EIDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [NB*8-1:0]  din,
  input  logic             flip,
  input  logic [IW-1:0]    idx,
  input  logic [2:0]       bsel,
  output logic [NB*8-1:0]  q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      q <= '0;
    else if (load)
      q <= din;
    else if (flip)
      q[{idx, bsel}] <= ~q[{idx, bsel}];
  end
endmodule

// File: rtl/bch_fix_applier.sv
module bch_fix_applier
  import bfa_pkg::*;
#(
  parameter int SEC_BYTES = SECTOR_B,
  parameter int ECC_BYTES = ECC_MAXB,
  parameter int CNT_W     = 5,
  localparam int EW = ECC_BYTES * 8,
  localparam int AW = $clog2(SEC_BYTES),
  localparam int IW = $clog2(ECC_BYTES),
  localparam int LW = LOC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic [CNT_W-1:0] loc_count,
  input  logic [EW-1:0]    calc_ecc,
  input  logic [EW-1:0]    stored_ecc,
  output logic [EW-1:0]    syn_out,
  input  logic             loc_valid,
  input  logic [LW-1:0]    loc_data,
  output logic             loc_ready,
  output logic             buf_rd_en,
  output logic             buf_wr_en,
  output logic [AW-1:0]    buf_addr,
  output logic [7:0]       buf_wr_data,
  input  logic [7:0]       buf_rd_data,
  output logic [EW-1:0]    ecc_fixed,
  output logic             done,
  output logic             fail,
  output logic [CNT_W-1:0] corrected
);
  phase_e            st_q, st_n;
  strength_e         str_q;
  logic [EW-1:0]     calc_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  ncorr_q;
  logic              fail_q;
  logic [AW-1:0]     pend_addr_q;
  logic [2:0]        pend_bit_q;

  hit_e              hit;
  logic [AW-1:0]     daddr;
  logic [IW-1:0]     eidx;
  logic [2:0]        bsel;
  logic              calc_clean, stored_blank;

  // Named internal events for the checker.
  logic take;
  logic skip_evt;
  logic ecc_flip;
  logic sess_load;

  assign take      = loc_valid && loc_ready;
  assign skip_evt  = (st_q == ST_CHECK) && (calc_clean || stored_blank);
  assign ecc_flip  = take && (hit == HIT_ECC);
  assign sess_load = (st_q == ST_IDLE) && start;

  bfa_loc_map #(.SEC(SEC_BYTES), .LW(LW), .PW(POS_W), .AW(AW), .IW(IW)) u_map (
    .str   (str_q),
    .loc   (loc_data),
    .hit   (hit),
    .daddr (daddr),
    .eidx  (eidx),
    .bsel  (bsel)
  );

  bfa_skip_detect #(.NB(ECC_BYTES)) u_skip (
    .str          (str_q),
    .calc         (calc_q),
    .stored       (ecc_fixed),
    .calc_clean   (calc_clean),
    .stored_blank (stored_blank)
  );

  bfa_syn_order #(.NB(ECC_BYTES), .NB8(ECC_B8)) u_syn (
    .str  (str_q),
    .calc (calc_q),
    .syn  (syn_out)
  );

  bfa_ecc_copy #(.NB(ECC_BYTES), .IW(IW)) u_ecc (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (sess_load),
    .din   (stored_ecc),
    .flip  (ecc_flip),
    .idx   (eidx),
    .bsel  (bsel),
    .q     (ecc_fixed)
  );

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE:  if (start) st_n = ST_CHECK;
      ST_CHECK: begin
        if (calc_clean || stored_blank) st_n = ST_DONE;
        else if (left_q == '0)          st_n = ST_DONE;
        else                            st_n = ST_TAKE;
      end
      ST_TAKE: begin
        if (take) begin
          if (hit == HIT_DATA)               st_n = ST_READ;
          else if (left_q == CNT_W'(1))      st_n = ST_DONE;
          else                               st_n = ST_TAKE;
        end
      end
      ST_READ:  st_n = ST_WRITE;
      ST_WRITE: st_n = (left_q == '0) ? ST_DONE : ST_TAKE;
      ST_DONE:  st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      str_q       <= STR_T8;
      calc_q      <= '0;
      left_q      <= '0;
      ncorr_q     <= '0;
      fail_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_bit_q  <= '0;
    end else begin
      st_q <= st_n;
      case (st_q)
        ST_IDLE: if (start) begin
          str_q   <= strength_e'(mode);
          calc_q  <= calc_ecc;
          left_q  <= loc_count;
          ncorr_q <= '0;
          fail_q  <= 1'b0;
        end
        ST_TAKE: if (take) begin
          left_q <= left_q - CNT_W'(1);
          case (hit)
            HIT_DATA: begin
              pend_addr_q <= daddr;
              pend_bit_q  <= bsel;
            end
            HIT_ECC: ncorr_q <= ncorr_q + CNT_W'(1);
            default: fail_q  <= 1'b1;
          endcase
        end
        ST_WRITE: ncorr_q <= ncorr_q + CNT_W'(1);
        default: ;
      endcase
    end
  end

  assign loc_ready   = (st_q == ST_TAKE);
  assign buf_rd_en   = (st_q == ST_READ);
  assign buf_wr_en   = (st_q == ST_WRITE);
  assign buf_addr    = pend_addr_q;
  assign buf_wr_data = buf_rd_data ^ (8'b1 << pend_bit_q);
  assign done        = (st_q == ST_DONE);
  assign fail        = fail_q;
  assign corrected   = fail_q ? '0 : ncorr_q;
endmodule

// File: rtl/bfa_chk.sv
module bfa_chk #(
  parameter int CNT_W = 5,
  parameter int AW    = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             loc_valid,
  input logic             loc_ready,
  input logic             buf_rd_en,
  input logic             buf_wr_en,
  input logic [AW-1:0]    buf_addr,
  input logic             done,
  input logic             fail,
  input logic [CNT_W-1:0] corrected,
  input logic             skip_evt
);
  assert_rmw_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr_en |-> ($past(buf_rd_en) && ($past(buf_addr) == buf_addr)));

  assert_one_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buf_rd_en, buf_wr_en}));

  assert_read_after_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd_en |-> $past(loc_valid && loc_ready));

  assert_no_take_in_rmw_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd_en || buf_wr_en) |-> !loc_ready);

  assert_skip_ends_R2: assert property (@(posedge clk) disable iff (!rst_n)
    skip_evt |=> (done && !fail && (corrected == '0)));

  assert_fail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fail) |-> (corrected == '0));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(loc_ready || buf_rd_en || buf_wr_en));
endmodule

bind bch_fix_applier bfa_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .loc_valid (loc_valid),
  .loc_ready (loc_ready),
  .buf_rd_en (buf_rd_en),
  .buf_wr_en (buf_wr_en),
  .buf_addr  (buf_addr),
  .done      (done),
  .fail      (fail),
  .corrected (corrected),
  .skip_evt  (skip_evt)
);

// File: tb/bch_fix_applier_test.sv
module bch_fix_applier_test;
  localparam int NB = 26;
  localparam int EW = NB * 8;
  localparam int CW = 5;
  localparam int NV = 12;

  // Table: mode, location, kind (0 data, 1 ecc, 2 invalid), index, bit
  localparam int V_MODE[NV] = '{0, 0, 0, 0, 0, 0, 1, 1, 1, 1, 1, 1};
  localparam int V_LOC [NV] = '{0, 104, 4199, 4200, 100, 4100, 0, 4303, 4304, 208, 1000, 4095};
  localparam int V_KIND[NV] = '{1, 0, 0, 2, 1, 0, 1, 0, 2, 0, 0, 0};
  localparam int V_IDX [NV] = '{12, 511, 0, 0, 0, 12, 25, 0, 0, 511, 412, 26};
  localparam int V_BIT [NV] = '{0, 0, 7, 0, 4, 4, 0, 7, 0, 0, 0, 7};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          mode = 1'b0;
  logic [CW-1:0] loc_count = '0;
  logic [EW-1:0] calc_ecc = '0;
  logic [EW-1:0] stored_ecc = '0;
  logic [EW-1:0] syn_out;
  logic          loc_valid = 1'b0;
  logic [12:0]   loc_data = '0;
  logic          loc_ready;
  logic          buf_rd_en, buf_wr_en;
  logic [8:0]    buf_addr;
  logic [7:0]    buf_wr_data;
  logic [7:0]    rdq;
  logic [EW-1:0] ecc_fixed;
  logic          done, fail;
  logic [CW-1:0] corrected;

  bch_fix_applier uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .loc_count(loc_count),
    .calc_ecc(calc_ecc), .stored_ecc(stored_ecc), .syn_out(syn_out),
    .loc_valid(loc_valid), .loc_data(loc_data), .loc_ready(loc_ready),
    .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en), .buf_addr(buf_addr),
    .buf_wr_data(buf_wr_data), .buf_rd_data(rdq), .ecc_fixed(ecc_fixed),
    .done(done), .fail(fail), .corrected(corrected)
  );

  function automatic logic [7:0] dpat(int i); return 8'(i) ^ 8'h5A; endfunction
  function automatic logic [7:0] spat(int i); return 8'h10 + 8'(i); endfunction
  function automatic logic [7:0] cpat(int i); return 8'(i + 1); endfunction

  // Sector buffer model with one-cycle read latency.
  logic [7:0] mem [512];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= dpat(i);
      rdq <= '0;
    end else begin
      if (buf_rd_en) rdq <= mem[buf_addr];
      if (buf_wr_en) mem[buf_addr] <= buf_wr_data;
    end
  end

  int ready_cnt = 0;
  always @(posedge clk) if (loc_ready) ready_cnt <= ready_cnt + 1;

  logic [7:0]    exp_mem [512];
  logic [EW-1:0] exp_ecc;
  int            lq [4];
  int            checks = 0;
  int            failures = 0;
  logic          got_done;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ecc(input bit zero_calc);
    for (int i = 0; i < NB; i++) begin
      calc_ecc[8*i +: 8]   = zero_calc ? 8'h00 : cpat(i);
      stored_ecc[8*i +: 8] = spat(i);
    end
  endtask

  task automatic session(input logic m, input int n, input int nsend);
    int g;
    @(negedge clk);
    mode = m; loc_count = CW'(n); start = 1'b1;
    exp_ecc = stored_ecc;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < nsend; k++) begin
      loc_data = 13'(lq[k]);
      loc_valid = 1'b1;
      g = 0;
      while (!loc_ready && g < 200) begin @(negedge clk); g++; end
      @(negedge clk);
      loc_valid = 1'b0;
    end
    g = 0;
    while (!done && g < 200) begin @(negedge clk); g++; end
    got_done = done;
  endtask

  task automatic flip_mem(input int idx, input int b);
    exp_mem[idx] = exp_mem[idx] ^ (8'b1 << b);
  endtask

  task automatic flip_ecc(input int idx, input int b);
    exp_ecc[8*idx + b] = ~exp_ecc[8*idx + b];
  endtask

  task automatic check_all_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 512; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int r0;
    for (int i = 0; i < 512; i++) exp_mem[i] = dpat(i);
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!done && !loc_ready && !buf_rd_en && !buf_wr_en && !fail && corrected == 0,
        "R1 in reset", {done, loc_ready, buf_rd_en, buf_wr_en, fail}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!done && !loc_ready && !buf_rd_en && !buf_wr_en && !fail && corrected == 0,
        "R1 after reset", {done, loc_ready, buf_rd_en, buf_wr_en, fail}, 0);

    // Table of single-location sessions (R4, R5, R6, R7, R8)
    for (int v = 0; v < NV; v++) begin
      set_ecc(1'b0);
      lq[0] = V_LOC[v];
      session(V_MODE[v] != 0, 1, 1);
      chk(got_done == 1'b1, "R11 session ends", got_done, 1);
      if (V_KIND[v] == 0) begin
        flip_mem(V_IDX[v], V_BIT[v]);
        chk(mem[V_IDX[v]] == exp_mem[V_IDX[v]], V_MODE[v] != 0 ? "R5 R6 data flip" : "R4 R6 data flip",
            mem[V_IDX[v]], exp_mem[V_IDX[v]]);
        chk(!fail && corrected == 1, "R9 count", corrected, 1);
      end else if (V_KIND[v] == 1) begin
        flip_ecc(V_IDX[v], V_BIT[v]);
        chk(ecc_fixed == exp_ecc, "R7 ecc flip", ecc_fixed[8*V_IDX[v] +: 8], exp_ecc[8*V_IDX[v] +: 8]);
        chk(!fail && corrected == 1, "R9 count", corrected, 1);
      end else begin
        chk(fail == 1'b1 && corrected == 0, "R8 invalid", {fail, corrected}, 6'h20);
        chk(ecc_fixed == exp_ecc, "R8 ecc untouched", 0, 0);
        check_all_mem("R8 data untouched");
      end
    end

    // R10: reversed order, 8-bit then 16-bit
    set_ecc(1'b0);
    session(1'b0, 0, 0);
    chk(syn_out[7:0] == 8'd13 && syn_out[8*12 +: 8] == 8'd1 && syn_out[8*13 +: 8] == 8'd14,
        "R10 8-bit order", syn_out[7:0], 13);
    chk(!fail && corrected == 0 && got_done, "R12 zero count", corrected, 0);
    session(1'b1, 0, 0);
    chk(syn_out[7:0] == 8'd26 && syn_out[8*25 +: 8] == 8'd1, "R10 16-bit order", syn_out[7:0], 26);

    // R2: clean sector, padding byte nonzero
    set_ecc(1'b1);
    calc_ecc[8*13 +: 8] = 8'h77;
    r0 = ready_cnt;
    lq[0] = 104;
    session(1'b0, 2, 0);
    chk(got_done && !fail && corrected == 0, "R2 clean done", corrected, 0);
    chk(ready_cnt == r0, "R2 no location taken", ready_cnt - r0, 0);
    chk(ecc_fixed == stored_ecc, "R2 ecc unchanged", 0, 0);
    check_all_mem("R2 data unchanged");

    // R3: erased page in 8-bit mode, bytes beyond 12 not 0xFF
    set_ecc(1'b0);
    for (int i = 0; i < 13; i++) stored_ecc[8*i +: 8] = 8'hFF;
    r0 = ready_cnt;
    session(1'b0, 1, 0);
    chk(got_done && !fail && corrected == 0 && ready_cnt == r0, "R3 erased", ready_cnt - r0, 0);
    chk(ecc_fixed == stored_ecc, "R3 ecc unchanged", 0, 0);
    // Same stored bytes in 16-bit mode are not erased
    lq[0] = 0;
    session(1'b1, 1, 1);
    flip_ecc(25, 0);
    chk(ecc_fixed == exp_ecc && corrected == 1, "R3 16-bit not erased", corrected, 1);

    // R8: invalid in the middle, later ones still applied
    set_ecc(1'b0);
    lq[0] = 0; lq[1] = 4304; lq[2] = 208;
    session(1'b1, 3, 3);
    flip_ecc(25, 0);
    flip_mem(511, 0);
    chk(fail == 1'b1 && corrected == 0, "R8 fail reported", {fail, corrected}, 6'h20);
    chk(ecc_fixed == exp_ecc, "R8 earlier ecc flip kept", ecc_fixed[8*25 +: 8], exp_ecc[8*25 +: 8]);
    chk(mem[511] == exp_mem[511], "R8 later data flip applied", mem[511], exp_mem[511]);

    // R9: three good locations mixed
    lq[0] = 104; lq[1] = 100; lq[2] = 4199;
    session(1'b0, 3, 3);
    flip_mem(511, 0); flip_ecc(0, 4); flip_mem(0, 7);
    chk(!fail && corrected == 3, "R9 three corrected", corrected, 3);
    chk(ecc_fixed == exp_ecc, "R9 ecc", ecc_fixed[7:0], exp_ecc[7:0]);
    check_all_mem("R9 data");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule